// File: doc/BRIEF.md
# Auto-Increment Colour Palette Lookup

This block is the colour lookup stage of a video controller. It holds 256 colours of 24 bits each. Software loads it through a register bus shared with the rest of the controller. A single bus word carries a register-select code and a value. One code returns the internal write pointer to entry 0. A second code stores a colour at the pointer and then moves the pointer forward by one. Loading the whole table therefore takes one pointer clear followed by a stream of colour writes.

On the display side, each pixel is turned into 8-bit red, green and blue outputs, one cycle after it is presented. The bits-per-pixel selector controls how the pixel forms the table indices. Depths up to 8 bpp use a single zero-extended index for all three channels. At 16 and 32 bpp, each channel reads the table through its own slice of the pixel. A grey ramp loaded into the table gives direct colour at 32 bpp.

Top module: `palette_lut`

## Requirements
- R1: After reset the write pointer is 0, every table entry is 0, and `red_o`, `grn_o` and `blu_o` are 0.
- R2: A bus write whose select field `bus_word_i[31:28]` equals 4'hA sets the write pointer to 0 and leaves the table unchanged.
- R3: A bus write with select 4'hB stores `bus_word_i[23:0]` at the write pointer and then advances the pointer by one. The colour fields are red [7:0], green [15:8] and blue [23:16].
- R4: The pointer wraps from 255 to 0, so the colour write after entry 255 lands in entry 0.
- R5: Bits [27:24] of a bus word have no effect on the stored colour.
- R6: A bus write with any other select code, and any cycle with `bus_we_i` low, changes neither the table nor the pointer.
- R7: `bpp_i` values 0, 1, 2 and 3 select 1, 2, 4 and 8 bpp. The index is `pix_i` bits [0], [1:0], [3:0] or [7:0], zero-extended. All three channels use that one entry.
- R8: When `bpp_i` is 4 (16 bpp), red comes from entry `pix_i[7:0]`, green from entry `pix_i[11:4]`, and blue from entry `pix_i[15:8]`.
- R9: When `bpp_i` is 6 (32 bpp), red comes from entry `pix_i[7:0]`, green from entry `pix_i[15:8]`, and blue from entry `pix_i[23:16]`. With entry i holding i in all three fields, the outputs equal those pixel bytes.
- R10: The colour outputs reflect the pixel and selector presented one cycle earlier. A colour write in that same cycle is not visible to the read, even at the same entry.
- R11: The unused `bpp_i` codes 5 and 7 behave as 8 bpp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register bus write strobe |
| bus_word_i | input | 32 | Select code in [31:28], value in [23:0] |
| bpp_i | input | 3 | Bits-per-pixel selector |
| pix_i | input | 32 | Pixel value |
| red_o | output | 8 | Red output, registered |
| grn_o | output | 8 | Green output, registered |
| blu_o | output | 8 | Blue output, registered |

## Verification
There is no read-back path, so a corrupted pointer only shows up indirectly. It appears at the outputs the first time a pixel lands on an entry that a misplaced write filled or skipped. The bench therefore loads full tables and reads many pixels across every depth. A wrong slice in 16 or 32 bpp mode breaks a single channel in the cycle after the pixel, and mismatched red, green and blue fields expose it. A read that catches its own cycle's write returns the new colour one cycle early, and the same-entry collision test catches that.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam int unsigned CH_W     = 8;
  localparam int unsigned NUM_CH   = 3;
  localparam int unsigned COLOUR_W = CH_W * NUM_CH;
  localparam int unsigned SEL_W    = 4;

  localparam logic [SEL_W-1:0] SEL_IDX_CLR = 4'hA;
  localparam logic [SEL_W-1:0] SEL_COLOUR  = 4'hB;

  localparam logic [2:0] BPP_1  = 3'd0;
  localparam logic [2:0] BPP_2  = 3'd1;
  localparam logic [2:0] BPP_4  = 3'd2;
  localparam logic [2:0] BPP_8  = 3'd3;
  localparam logic [2:0] BPP_16 = 3'd4;
  localparam logic [2:0] BPP_32 = 3'd6;
endpackage

// File: rtl/palette_wr_ctrl.sv
module palette_wr_ctrl
  import palette_pkg::*;
#(
  parameter int unsigned DEPTH   = 256,
  parameter int unsigned BUS_W   = 32,
  parameter int unsigned SEL_LSB = 28,
  localparam int unsigned AW     = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [BUS_W-1:0]    word_i,
  output logic                wr_en_o,
  output logic [AW-1:0]       wr_addr_o,
  output logic [COLOUR_W-1:0] wr_data_o
);
  logic [SEL_W-1:0] sel;
  logic             clr, put;
  logic [AW-1:0]    idx_q;

  assign sel = word_i[SEL_LSB +: SEL_W];
  assign clr = we_i && (sel == SEL_IDX_CLR);
  assign put = we_i && (sel == SEL_COLOUR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  idx_q <= '0;
    else if (clr) idx_q <= '0;
    else if (put) idx_q <= (idx_q == AW'(DEPTH - 1)) ? '0 : idx_q + 1'b1;
  end

  assign wr_en_o   = put;
  assign wr_addr_o = idx_q;
  assign wr_data_o = word_i[COLOUR_W-1:0];

  assert_idx_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (idx_q == '0));
  assert_idx_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (put && idx_q != AW'(DEPTH - 1)) |=> (idx_q == $past(idx_q) + 1'b1));
  assert_idx_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (put && idx_q == AW'(DEPTH - 1)) |=> (idx_q == '0));
  assert_idx_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr || put) |=> $stable(idx_q));
endmodule

// File: rtl/palette_idx_map.sv
module palette_idx_map
  import palette_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned PIX_W = 32
) (
  input  logic [2:0]           bpp_i,
  input  logic [PIX_W-1:0]     pix_i,
  output logic [NUM_CH*AW-1:0] idx_o
);
  localparam int unsigned HALF = AW / 2;
  logic [AW-1:0] mask;

  always_comb begin
    case (bpp_i)
      BPP_1:   mask = AW'(1);
      BPP_2:   mask = AW'(3);
      BPP_4:   mask = AW'(15);
      default: mask = '1;
    endcase
    case (bpp_i)
      BPP_16:  idx_o = {pix_i[AW +: AW], pix_i[HALF +: AW], pix_i[0 +: AW]};
      BPP_32:  idx_o = {pix_i[2*AW +: AW], pix_i[AW +: AW], pix_i[0 +: AW]};
      default: idx_o = {NUM_CH{pix_i[AW-1:0] & mask}};
    endcase
  end
endmodule

// File: rtl/palette_store.sv
module palette_store
  import palette_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [AW-1:0]         wr_addr_i,
  input  logic [COLOUR_W-1:0]   wr_data_i,
  input  logic [NUM_CH*AW-1:0]  rd_idx_i,
  output logic [COLOUR_W-1:0]   rd_o
);
  logic [COLOUR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en_i) begin
      mem[wr_addr_i] <= wr_data_i;
    end
  end

  // each channel port reads only its own field, before this cycle's write
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rd_o[ch*CH_W +: CH_W] <= '0;
      else         rd_o[ch*CH_W +: CH_W] <= mem[rd_idx_i[ch*AW +: AW]][ch*CH_W +: CH_W];
    end
  end

  assert_entry_stored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (mem[$past(wr_addr_i)] == $past(wr_data_i)));
endmodule

// File: rtl/palette_lut.sv
module palette_lut
  import palette_pkg::*;
#(
  parameter int unsigned DEPTH   = 256,
  parameter int unsigned BUS_W   = 32,
  parameter int unsigned SEL_LSB = 28,
  parameter int unsigned PIX_W   = 32,
  localparam int unsigned AW     = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_we_i,
  input  logic [BUS_W-1:0] bus_word_i,
  input  logic [2:0]       bpp_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic [CH_W-1:0]  red_o,
  output logic [CH_W-1:0]  grn_o,
  output logic [CH_W-1:0]  blu_o
);
  logic                  wr_en;
  logic [AW-1:0]         wr_addr;
  logic [COLOUR_W-1:0]   wr_data;
  logic [NUM_CH*AW-1:0]  rd_idx;
  logic [COLOUR_W-1:0]   rd;

  palette_wr_ctrl #(.DEPTH(DEPTH), .BUS_W(BUS_W), .SEL_LSB(SEL_LSB)) u_wr_ctrl (
    .clk_i, .rst_ni, .we_i(bus_we_i), .word_i(bus_word_i),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  palette_idx_map #(.AW(AW), .PIX_W(PIX_W)) u_idx_map (
    .bpp_i, .pix_i, .idx_o(rd_idx)
  );

  palette_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_o(rd)
  );

  assign red_o = rd[0*CH_W +: CH_W];
  assign grn_o = rd[1*CH_W +: CH_W];
  assign blu_o = rd[2*CH_W +: CH_W];

  assert_shared_idx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bpp_i <= BPP_8) |-> (rd_idx[0 +: AW] == rd_idx[AW +: AW] &&
                          rd_idx[AW +: AW] == rd_idx[2*AW +: AW]));
  assert_one_bit_idx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bpp_i == BPP_1) |-> (rd_idx[AW-1:1] == '0));
  assert_red_slice_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bpp_i == BPP_16 || bpp_i == BPP_32) |-> (rd_idx[0 +: AW] == pix_i[AW-1:0]));
endmodule

// File: tb/palette_lut_bench.sv
module palette_lut_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_word = '0;
  logic [2:0]  bpp = 3'd3;
  logic [31:0] pix = '0;
  logic [7:0]  red, grn, blu;

  int checks = 0;
  int errors = 0;
  logic [23:0] mdl [256];
  int          midx = 0;
  logic [23:0] exp_rgb = '0;
  string       exp_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  palette_lut u_palette_lut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(bus_we), .bus_word_i(bus_word),
    .bpp_i(bpp), .pix_i(pix), .red_o(red), .grn_o(grn), .blu_o(blu)
  );

  function automatic logic [31:0] word(input logic [3:0] code, input logic [23:0] v);
    return {code, 4'h0, v};
  endfunction

  function automatic logic [23:0] lookup(input logic [2:0] b, input logic [31:0] p);
    int ri, gi, bi;
    case (b)
      3'd0: begin ri = p & 1;  gi = ri; bi = ri; end
      3'd1: begin ri = p & 3;  gi = ri; bi = ri; end
      3'd2: begin ri = p & 15; gi = ri; bi = ri; end
      3'd4: begin ri = p & 255; gi = (p >> 4) & 255; bi = (p >> 8) & 255; end
      3'd6: begin ri = p & 255; gi = (p >> 8) & 255; bi = (p >> 16) & 255; end
      default: begin ri = p & 255; gi = ri; bi = ri; end
    endcase
    return {mdl[bi][23:16], mdl[gi][15:8], mdl[ri][7:0]};
  endfunction

  task automatic step(input bit we, input logic [31:0] w, input logic [2:0] b,
                      input logic [31:0] p, input string tag);
    @(negedge clk);
    checks++;
    if ({blu, grn, red} !== exp_rgb) begin
      errors++;
      $display("FAIL %s: rgb actual %h_%h_%h expected %h_%h_%h", exp_tag,
               red, grn, blu, exp_rgb[7:0], exp_rgb[15:8], exp_rgb[23:16]);
    end
    bus_we = we; bus_word = w; bpp = b; pix = p;
    exp_rgb = lookup(b, p);   // read sees table before this cycle's write (R10)
    exp_tag = tag;
    if (we) begin
      if (w[31:28] == 4'hA) midx = 0;
      else if (w[31:28] == 4'hB) begin
        mdl[midx] = w[23:0];
        midx = (midx + 1) % 256;
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int i = 0; i < 4; i++) step(0, '0, 3'd3, 32'(i * 77), "R1");
    // R2 R3: clear then full load
    step(1, word(4'hA, 24'h123456), 3'd3, '0, "R2");
    for (int i = 0; i < 256; i++)
      step(1, word(4'hB, {8'(i ^ 8'h5A), 8'(i * 3), 8'(i + 7)}), 3'd3, 32'(i), "R3");
    for (int i = 0; i < 256; i += 5) step(0, '0, 3'd3, 32'(i), "R3");
    // R4: wrap overwrites entries 0 and 1
    step(1, word(4'hB, 24'hC0FFEE), 3'd3, '0, "R4");
    step(1, word(4'hB, 24'hBADA55), 3'd3, 32'd1, "R4");
    step(0, '0, 3'd3, 32'd0, "R4");
    step(0, '0, 3'd3, 32'd1, "R4");
    // R6: other codes ignored; pointer stays at 2
    step(1, word(4'h3, 24'hFFFFFF), 3'd3, 32'd2, "R6");
    step(1, word(4'h0, 24'hEEEEEE), 3'd3, 32'd2, "R6");
    step(0, word(4'hB, 24'hDDDDDD), 3'd3, 32'd2, "R6");
    step(1, word(4'hB, 24'h0A0B0C), 3'd3, 32'd3, "R6");
    step(0, '0, 3'd3, 32'd2, "R6");
    step(0, '0, 3'd3, 32'd3, "R6");
    // R5: upper junk bits dropped
    step(1, word(4'hB, 24'h445566) | 32'h0F00_0000, 3'd3, '0, "R5");
    step(0, '0, 3'd3, 32'd3, "R5");
    // R7 R8 R9 R11 across depths
    for (int i = 0; i < 48; i++) begin
      logic [31:0] p;
      p = 32'(i) * 32'h9E37_79B1 + 32'h1357;
      step(0, '0, 3'd0, p, "R7");
      step(0, '0, 3'd1, p, "R7");
      step(0, '0, 3'd2, p, "R7");
      step(0, '0, 3'd3, p, "R7");
      step(0, '0, 3'd4, p, "R8");
      step(0, '0, 3'd6, p, "R9");
      step(0, '0, 3'd5, p, "R11");
      step(0, '0, 3'd7, p, "R11");
    end
    // R9: grey ramp pass-through
    step(1, word(4'hA, 24'h0), 3'd3, '0, "R2");
    for (int i = 0; i < 256; i++) step(1, word(4'hB, {3{8'(i)}}), 3'd3, '0, "R9");
    for (int i = 0; i < 40; i++) step(0, '0, 3'd6, 32'(i) * 32'h0103_0507, "R9");
    // R10: write and read of the same entry in one cycle
    step(1, word(4'hA, 24'h0), 3'd3, '0, "R2");
    step(1, word(4'hB, 24'h778899), 3'd3, 32'd0, "R10");
    step(0, '0, 3'd3, 32'd0, "R10");
    step(1, word(4'hB, 24'h112233), 3'd4, 32'h0000_0101, "R10");
    step(0, '0, 3'd4, 32'h0000_0101, "R10");
    step(0, '0, 3'd3, '0, "R10");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule